// File: doc/BRIEF.md
# Serial Peripheral Port with Selectable Bit Clock

An 8-bit, full-duplex serial peripheral port for a small microcontroller, reached over a narrow host register bus. One 3-bit role field sets the port's part on the link. As master it generates the serial clock from one of five sources: three fixed divisions of the system clock, a sub-oscillator strobe, or every second timer strobe. As slave it shifts on edges of an external serial clock. A host write to the data register loads the shift buffer. In master mode that write also starts a byte. A host read of the data register returns the last received byte.

Two host bits choose the clock idle level and the sampling edge. A transfer-complete flag records each received byte, and a select-enable bit either drives the slave-select pin or lets it float. The system, sub-oscillator and timer clocks are not generated here. The sub-oscillator and timer clocks arrive as single-cycle enable strobes, and the three system divisions come from a free-running prescaler inside the block.

Top module: `spi_port`

## Requirements
- R1: Register 0 (address 0) holds the role code in bits 7..5 and the enable in bit 1. All other bits read 0. After reset the role code is 111 and the enable is 0, so the register reads 0xE0.
- R2: In master role the serial clock toggles once per qualifying tick, 16 toggles per byte. Codes 000/001/010 tick every 4/16/64 system clocks, on the cycles where the number of clocks since reset, taken modulo the division, equals the division minus one. Code 011 ticks on each sub-oscillator strobe. Code 100 ticks on every second timer strobe counted since reset (the 2nd, 4th, ...).
- R3: A host write to the data register (address 2) while enabled, in a master role and idle starts a byte, shifted out MSB first. Busy (register 1, bit 1) stays high until the sixteenth clock edge. A data write while busy is ignored.
- R4: Register 1 bit 2 is the clock idle level. With register 1 bit 3 at 0, the port samples input on odd-numbered clock edges and shifts output on even-numbered ones. With bit 3 at 1, the first edge does nothing, later odd-numbered edges shift and even-numbered edges sample.
- R5: At the eighth sample the received byte (MSB first) is latched into the register that data reads return, and the done flag (register 1, bit 0) is set.
- R6: Writing register 1 with bit 0 at 0 clears the done flag. Writing it with bit 0 at 1 leaves the flag unchanged.
- R7: Role codes 110 and 111 produce no serial clock, and a data write under them starts no transfer.
- R8: With the enable at 0, every pin output enable is low and a running transfer is abandoned (busy drops).
- R9: Register 1 bit 4 is select-enable. With it at 1 a master drives slave-select low exactly while busy. With it at 0 the slave-select output enable is low.
- R10: Role 101 is slave. A data write loads the byte to send. With select-enable at 1 the slave shifts only while slave-select is low; when deselected, its data output floats and its bit count restarts. With select-enable at 0 the slave counts as always selected.
- R11: After reset, register 1 and the data register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address (0 control, 1 setup/status, 2 data) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| stb_sub | input | 1 | Sub-oscillator enable strobe |
| stb_tmr | input | 1 | Timer output enable strobe |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output enable |
| ss_i | input | 1 | Slave-select input, active low |
| ss_o | output | 1 | Slave-select output, active low |
| ss_oe | output | 1 | Slave-select output enable |

## Verification
A wrong bit counter or phase flop shows at the clock pin within one tick: an extra or missing toggle, or a clock left away from its idle level once busy falls. A shift register that advances on the wrong edge puts a wrong bit on the data output before the next sampling edge. A wrong receive path shows only when the byte is read back after the eighth sample. For that reason the master path is compared against a behavioural model on every clock, and each received byte and the done flag are read back through the host bus at the end of every transfer.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef enum logic [2:0] {
      ROLE_M_DIV_A = 3'b000,
      ROLE_M_DIV_B = 3'b001,
      ROLE_M_DIV_C = 3'b010,
      ROLE_M_SUB   = 3'b011,
      ROLE_M_TMR   = 3'b100,
      ROLE_SLAVE   = 3'b101,
      ROLE_RSV_A   = 3'b110,
      ROLE_RSV_B   = 3'b111
   } role_e;

   localparam logic [1:0] ADR_CTRL  = 2'd0;
   localparam logic [1:0] ADR_SETUP = 2'd1;
   localparam logic [1:0] ADR_DATA  = 2'd2;

   localparam int CTRL_ROLE_LSB = 5;
   localparam int CTRL_EN_BIT   = 1;
   localparam int SET_DONE_BIT  = 0;
   localparam int SET_BUSY_BIT  = 1;
   localparam int SET_CPOL_BIT  = 2;
   localparam int SET_CPHA_BIT  = 3;
   localparam int SET_CSEN_BIT  = 4;

   typedef struct packed {
      role_e role;
      logic  en;
      logic  csen;
      logic  cpha;
      logic  cpol;
   } cfg_t;

   function automatic logic role_valid(role_e r);
      return r <= ROLE_SLAVE;
   endfunction

   function automatic logic role_master(role_e r);
      return r < ROLE_SLAVE;
   endfunction

endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
   import spi_port_pkg::*;
#(
   parameter int HW = 8,
   parameter int DW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [1:0]    host_addr,
   input  logic [HW-1:0] host_wdata,
   output logic [HW-1:0] host_rdata,
   input  logic          busy,
   input  logic          done_set,
   input  logic [DW-1:0] rx,
   output cfg_t          cfg,
   output logic          done,
   output logic          data_we
);

   logic wr_ctrl, wr_setup;

   assign wr_ctrl  = host_we && (host_addr == ADR_CTRL);
   assign wr_setup = host_we && (host_addr == ADR_SETUP);
   assign data_we  = host_we && (host_addr == ADR_DATA);

   wire unused_wbits = ^{host_wdata[HW-1:CTRL_ROLE_LSB+3], host_wdata[CTRL_ROLE_LSB-1:CTRL_EN_BIT+1],
                         host_wdata[CTRL_EN_BIT-1:0], host_wdata[HW-1:SET_CSEN_BIT+1],
                         host_wdata[SET_BUSY_BIT]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.role <= ROLE_RSV_B;
         cfg.en   <= 1'b0;
         cfg.csen <= 1'b0;
         cfg.cpha <= 1'b0;
         cfg.cpol <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            cfg.role <= role_e'(host_wdata[CTRL_ROLE_LSB +: 3]);
            cfg.en   <= host_wdata[CTRL_EN_BIT];
         end
         if (wr_setup) begin
            cfg.csen <= host_wdata[SET_CSEN_BIT];
            cfg.cpha <= host_wdata[SET_CPHA_BIT];
            cfg.cpol <= host_wdata[SET_CPOL_BIT];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done <= 1'b0;
      else if (done_set)
         done <= 1'b1;
      else if (wr_setup && !host_wdata[SET_DONE_BIT])
         done <= 1'b0;
   end

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         ADR_CTRL: begin
            host_rdata[CTRL_ROLE_LSB +: 3] = cfg.role;
            host_rdata[CTRL_EN_BIT]        = cfg.en;
         end
         ADR_SETUP: begin
            host_rdata[SET_DONE_BIT] = done;
            host_rdata[SET_BUSY_BIT] = busy;
            host_rdata[SET_CPOL_BIT] = cfg.cpol;
            host_rdata[SET_CPHA_BIT] = cfg.cpha;
            host_rdata[SET_CSEN_BIT] = cfg.csen;
         end
         ADR_DATA: host_rdata[DW-1:0] = rx;
         default:  host_rdata = '0;
      endcase
   end

endmodule

// File: rtl/spi_port_clksel.sv
module spi_port_clksel
   import spi_port_pkg::*;
#(
   parameter int DIV_A = 4,
   parameter int DIV_B = 16,
   parameter int DIV_C = 64
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run_master,
   input  role_e role,
   input  logic  stb_sub,
   input  logic  stb_tmr,
   output logic  tick
);

   localparam int NTAP = 3;
   localparam int DMAX = (DIV_C > DIV_B) ? ((DIV_C > DIV_A) ? DIV_C : DIV_A)
                                         : ((DIV_B > DIV_A) ? DIV_B : DIV_A);
   localparam int PW   = $clog2(DMAX);

   function automatic int div_of(int i);
      case (i)
         0:       return DIV_A;
         1:       return DIV_B;
         default: return DIV_C;
      endcase
   endfunction

   logic [PW-1:0]   pre;
   logic            tmr_half;
   logic [NTAP-1:0] tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre      <= '0;
         tmr_half <= 1'b0;
      end else begin
         pre <= pre + 1'b1;
         if (stb_tmr)
            tmr_half <= ~tmr_half;
      end
   end

   for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
      localparam int D = div_of(gi);
      localparam int W = $clog2(D);
      if (D < 2 || (D & (D - 1)) != 0) begin : g_bad_div
         $error("spi_port_clksel: each division must be a power of two of at least 2");
      end
      assign tap[gi] = &pre[W-1:0];
   end

   always_comb begin
      unique case (role)
         ROLE_M_DIV_A: tick = tap[0];
         ROLE_M_DIV_B: tick = tap[1];
         ROLE_M_DIV_C: tick = tap[2];
         ROLE_M_SUB:   tick = stb_sub;
         ROLE_M_TMR:   tick = stb_tmr && tmr_half;
         default:      tick = 1'b0;
      endcase
      tick = tick && run_master;
   end

endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
   parameter int DW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          master,
   input  logic          cpha,
   input  logic          start,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          m_tick,
   input  logic          sck_in,
   input  logic          sel,
   input  logic          sdi,
   output logic [DW-1:0] rx,
   output logic          done_set,
   output logic          busy,
   output logic          phase,
   output logic          sdo
);

   localparam int KW = $clog2(2 * DW);
   localparam logic [KW-1:0] K_LAST = KW'(2 * DW - 1);
   localparam logic [KW-1:0] K_FIN  = KW'(2 * DW - 2);

   logic [DW-1:0] sh;
   logic          bit_l;
   logic [KW-1:0] k;
   logic          sck_q;
   logic          s_edge, m_edge, ev, smp, final_smp, skip_sh;

   assign s_edge    = run && !master && sel && (sck_in != sck_q);
   assign m_edge    = run && master && busy && m_tick;
   assign ev        = s_edge || m_edge;
   assign smp       = (k[0] == cpha);
   assign final_smp = smp && (k[KW-1:1] == K_FIN[KW-1:1]);
   assign skip_sh   = cpha && (k == '0);
   assign done_set  = ev && final_smp;
   assign sdo       = sh[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sck_q <= 1'b0;
      else
         sck_q <= sck_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         bit_l <= 1'b0;
         k     <= '0;
         busy  <= 1'b0;
         phase <= 1'b0;
         rx    <= '0;
      end else if (!run) begin
         busy  <= 1'b0;
         k     <= '0;
         phase <= 1'b0;
         if (load)
            sh <= load_data;
      end else if (start) begin
         sh    <= load_data;
         busy  <= 1'b1;
         k     <= '0;
         phase <= 1'b0;
      end else if (!master && !sel) begin
         k     <= '0;
         phase <= 1'b0;
         if (load)
            sh <= load_data;
      end else if (ev) begin
         phase <= ~phase;
         k     <= (k == K_LAST) ? '0 : k + 1'b1;
         if (smp)
            bit_l <= sdi;
         else if (!skip_sh)
            sh <= {sh[DW-2:0], bit_l};
         if (final_smp)
            rx <= {sh[DW-2:0], sdi};
         if (master && k == K_LAST)
            busy <= 1'b0;
      end else if (load) begin
         sh <= load_data;
      end
   end

endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter int HW    = 8,
   parameter int DW    = 8,
   parameter int DIV_A = 4,
   parameter int DIV_B = 16,
   parameter int DIV_C = 64
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [1:0]    host_addr,
   input  logic [HW-1:0] host_wdata,
   output logic [HW-1:0] host_rdata,
   input  logic          stb_sub,
   input  logic          stb_tmr,
   input  logic          sck_i,
   output logic          sck_o,
   output logic          sck_oe,
   input  logic          sdi_i,
   output logic          sdo_o,
   output logic          sdo_oe,
   input  logic          ss_i,
   output logic          ss_o,
   output logic          ss_oe
);

   if (HW != 8) begin : g_bad_hw
      $error("spi_port: the register layout needs an 8-bit host bus");
   end
   if (DW < 2 || DW > HW) begin : g_bad_dw
      $error("spi_port: data width must lie between 2 and the host width");
   end

   cfg_t          cfg;
   logic          done, done_set, busy, phase, data_we, tick, sdo;
   logic          run, master, sel, start, load;
   logic [DW-1:0] rx;
   logic [2:0]    role_w;

   assign role_w = cfg.role;
   assign run    = cfg.en && role_valid(cfg.role);
   assign master = role_master(cfg.role);
   assign sel    = !cfg.csen || !ss_i;
   assign start  = data_we && run && master && !busy;
   assign load   = data_we && (cfg.role == ROLE_SLAVE);

   spi_port_regs #(.HW(HW), .DW(DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .busy       (busy),
      .done_set   (done_set),
      .rx         (rx),
      .cfg        (cfg),
      .done       (done),
      .data_we    (data_we)
   );

   spi_port_clksel #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clksel (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_master (run && master),
      .role       (cfg.role),
      .stb_sub    (stb_sub),
      .stb_tmr    (stb_tmr),
      .tick       (tick)
   );

   spi_port_shift #(.DW(DW)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .master    (master),
      .cpha      (cfg.cpha),
      .start     (start),
      .load      (load),
      .load_data (host_wdata[DW-1:0]),
      .m_tick    (tick),
      .sck_in    (sck_i),
      .sel       (sel),
      .sdi       (sdi_i),
      .rx        (rx),
      .done_set  (done_set),
      .busy      (busy),
      .phase     (phase),
      .sdo       (sdo)
   );

   assign sck_o  = cfg.cpol ^ phase;
   assign sck_oe = run && master;
   assign sdo_o  = sdo;
   assign sdo_oe = run && (master || sel);
   assign ss_o   = !busy;
   assign ss_oe  = run && master && cfg.csen;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
   parameter int DW = 8
)(
   input logic          clk,
   input logic          rst_n,
   input logic          host_we,
   input logic [1:0]    host_addr,
   input logic [7:0]    host_wdata,
   input logic [2:0]    role,
   input logic          en,
   input logic          csen,
   input logic          cpol,
   input logic          busy,
   input logic          done,
   input logic          done_set,
   input logic [DW-1:0] rx,
   input logic          sck_o,
   input logic          sck_oe,
   input logic          sdo_oe,
   input logic          ss_oe,
   input logic          ss_i
);

   // R8
   en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!sck_oe && !sdo_oe && !ss_oe));

   // R7
   reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role > 3'd5) |=> !busy);

   // R4
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sck_oe) |-> (sck_o == cpol));

   // R6
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == 2'd1 && !host_wdata[0] && !done_set) |=> !done);

   // R5
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_set |=> $stable(rx));

   // R9
   ss_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !csen |-> !ss_oe);

   // R10
   sdo_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role == 3'd5 && csen && ss_i) |-> !sdo_oe);

   // R3
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(host_we && host_addr == 2'd2));

endmodule

bind spi_port spi_port_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_we    (host_we),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .role       (role_w),
   .en         (cfg.en),
   .csen       (cfg.csen),
   .cpol       (cfg.cpol),
   .busy       (busy),
   .done       (done),
   .done_set   (done_set),
   .rx         (rx),
   .sck_o      (sck_o),
   .sck_oe     (sck_oe),
   .sdo_oe     (sdo_oe),
   .ss_oe      (ss_oe),
   .ss_i       (ss_i)
);

// File: tb/test_spi_port.sv
`timescale 1ns/100ps
module test_spi_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       stb_sub = 1'b0, stb_tmr = 1'b0;
   logic       sck_i = 1'b0, sdi_i = 1'b0, ss_i = 1'b1;
   logic       sck_o, sck_oe, sdo_o, sdo_oe, ss_o, ss_oe;

   int tests = 0, fails = 0;

   always #2.5 clk = ~clk;

   spi_port i_spi_port (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .stb_sub(stb_sub),
      .stb_tmr(stb_tmr), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .ss_i(ss_i),
      .ss_o(ss_o), .ss_oe(ss_oe)
   );

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- strobe sources ----------------
   int nb = 0;
   always @(negedge clk) begin
      nb++;
      stb_sub = (nb % 7 == 0);
      stb_tmr = (nb % 3 == 0);
   end

   // ---------------- behavioural reference of the master path ----------------
   int   m_role = 7, m_pre = 0, m_edge = 0, m_samp = 0;
   bit   m_en = 0, m_csen = 0, m_cpol = 0, m_cpha = 0;
   bit   m_busy = 0, m_done = 0, m_tpar = 0, m_tick = 0, m_run = 0, m_set = 0;
   bit   m_txq[$];
   int   m_rxacc = 0, m_rx = 0;
   bit   cmp_en = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_role = 7; m_pre = 0; m_edge = 0; m_busy = 0; m_done = 0; m_tpar = 0;
         m_en = 0; m_csen = 0; m_cpol = 0; m_cpha = 0; m_rx = 0;
      end else begin
         case (m_role)
            0: m_tick = (m_pre % 4 == 3);
            1: m_tick = (m_pre % 16 == 15);
            2: m_tick = (m_pre % 64 == 63);
            3: m_tick = stb_sub;
            4: m_tick = stb_tmr && m_tpar;
            default: m_tick = 0;
         endcase
         if (stb_tmr) m_tpar = !m_tpar;
         m_pre++;
         m_set = 0;
         m_run = m_en && (m_role <= 5);
         if (!m_run) begin
            m_busy = 0; m_edge = 0;
         end else if (host_we && host_addr == 2 && m_role < 5 && !m_busy) begin
            m_busy = 1; m_edge = 0; m_samp = 0; m_rxacc = 0;
            m_txq.delete();
            for (int b = 7; b >= 0; b--) m_txq.push_back(host_wdata[b]);
         end else if (m_busy && m_tick) begin
            if ((m_edge % 2) == m_cpha) begin
               m_rxacc = (m_rxacc << 1) | int'(sdi_i);
               m_samp++;
               if (m_samp == 8) begin m_rx = m_rxacc; m_done = 1; m_set = 1; end
            end else if (!(m_cpha && m_edge == 0)) begin
               if (m_txq.size() > 0) void'(m_txq.pop_front());
            end
            m_edge++;
            if (m_edge == 16) m_busy = 0;
         end
         if (host_we && host_addr == 1) begin
            m_csen = host_wdata[4]; m_cpha = host_wdata[3]; m_cpol = host_wdata[2];
            if (!host_wdata[0] && !m_set) m_done = 0;
         end
         if (host_we && host_addr == 0) begin
            m_role = int'(host_wdata[7:5]); m_en = host_wdata[1];
         end
      end
   end

   // per-clock comparison of pins against the reference
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         chk("R8 sck_oe", int'(sck_oe), int'(m_en && m_role < 5));
         chk("R9 ss_oe", int'(ss_oe), int'(m_en && m_role < 5 && m_csen));
         if (sck_oe) chk("R2 R4 sck_o", int'(sck_o), int'(m_cpol ^ (m_edge % 2)));
         if (ss_oe) chk("R3 ss_o", int'(ss_o), int'(!m_busy));
         if (m_busy && m_txq.size() > 0) chk("R3 sdo_o", int'(sdo_o), int'(m_txq[0]));
      end
   end

   // master receive data source and clock-toggle counter
   bit   drive_m = 0;
   logic [7:0] rx_pat = 8'h00;
   int   tog = 0;
   logic sck_prev = 1'b0;
   always @(negedge clk) begin
      if (drive_m) sdi_i = (m_samp < 8) ? rx_pat[7 - m_samp] : 1'b0;
      if (sck_oe && sck_o != sck_prev) tog++;
      sck_prev = sck_o;
   end

   // ---------------- host access ----------------
   task automatic host_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_read(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic run_master(logic [7:0] ctl0, logic [7:0] ctl1, logic [7:0] tx,
                             logic [7:0] rxp, bit poke_busy);
      logic [7:0] rd;
      int guard;
      host_write(2'd1, ctl1);
      host_write(2'd0, ctl0);
      rx_pat = rxp;
      drive_m = 1;
      @(negedge clk);
      tog = 0;
      host_write(2'd2, tx);
      if (poke_busy) begin
         repeat (12) @(negedge clk);
         host_write(2'd2, 8'hFF);   // R3: ignored while busy
      end
      guard = 0;
      while (m_busy && guard < 5000) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      chk("R2 toggles per byte", tog, 16);
      host_read(2'd2, rd);
      chk("R5 received byte", int'(rd), int'(rxp));
      host_read(2'd1, rd);
      chk("R5 done flag", int'(rd[0]), 1);
      chk("R3 busy cleared", int'(rd[1]), 0);
      drive_m = 0;
   endtask

   task automatic slave_bits(logic [7:0] tx, logic [7:0] mosi, int nbits,
                             output logic [7:0] got);
      got = 8'h00;
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         sdi_i = mosi[7 - i];
         got = {got[6:0], sdo_o};
         sck_i = 1'b1;
         repeat (2) @(negedge clk);
         sck_i = 1'b0;
         repeat (2) @(negedge clk);
      end
      if (tx != tx) got = 8'h00;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #750000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [7:0] rd, got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      host_read(2'd0, rd); chk("R1 reset control", int'(rd), 8'hE0);
      host_read(2'd1, rd); chk("R11 reset setup", int'(rd), 8'h00);
      host_read(2'd2, rd); chk("R11 reset data", int'(rd), 8'h00);
      chk("R7 no clock at reset", int'(sck_oe), 0);
      cmp_en = 1;

      // R1 unimplemented bits read 0; R7 reserved code stays idle
      host_write(2'd0, 8'hFF);
      host_read(2'd0, rd); chk("R1 readback", int'(rd), 8'hE2);
      host_write(2'd2, 8'h5A);
      repeat (100) @(negedge clk);
      host_read(2'd1, rd); chk("R7 reserved no busy", int'(rd[1]), 0);
      chk("R7 reserved no clock", int'(sck_oe), 0);
      host_write(2'd0, 8'hC2);
      host_write(2'd2, 8'h33);
      repeat (100) @(negedge clk);
      host_read(2'd1, rd); chk("R7 code 110 no busy", int'(rd[1]), 0);

      // master transfers over all five clock sources
      run_master(8'h02, 8'h10, 8'hA5, 8'h3C, 1'b1);
      host_write(2'd1, 8'h11);
      host_read(2'd1, rd); chk("R6 write one keeps done", int'(rd[0]), 1);
      host_write(2'd1, 8'h10);
      host_read(2'd1, rd); chk("R6 write zero clears done", int'(rd[0]), 0);

      run_master(8'h22, 8'h1C, 8'h96, 8'hC3, 1'b0);
      run_master(8'h42, 8'h04, 8'h01, 8'h80, 1'b0);
      chk("R9 select floats", int'(ss_oe), 0);
      run_master(8'h62, 8'h18, 8'hF0, 8'h0F, 1'b0);
      run_master(8'h82, 8'h14, 8'h3C, 8'h5A, 1'b0);

      // R8 abort by disable
      host_write(2'd1, 8'h10);
      host_write(2'd0, 8'h02);
      host_write(2'd2, 8'h77);
      repeat (20) @(negedge clk);
      host_write(2'd0, 8'h00);
      @(negedge clk);
      host_read(2'd1, rd); chk("R8 busy dropped", int'(rd[1]), 0);
      chk("R8 outputs off", int'({sck_oe, sdo_oe, ss_oe}), 0);

      // R10 slave role
      host_write(2'd1, 8'h10);
      host_write(2'd0, 8'hA2);
      ss_i = 1'b1; sck_i = 1'b0;
      host_write(2'd2, 8'h69);
      @(negedge clk);
      chk("R10 deselected data floats", int'(sdo_oe), 0);
      ss_i = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 selected data driven", int'(sdo_oe), 1);
      slave_bits(8'h69, 8'hB4, 8, got);
      chk("R10 slave sent byte", int'(got), 8'h69);
      host_read(2'd2, rd); chk("R10 slave received byte", int'(rd), 8'hB4);
      host_read(2'd1, rd); chk("R5 slave done", int'(rd[0]), 1);

      // R10 partial byte then deselect restarts the count
      slave_bits(8'h00, 8'hFF, 3, got);
      ss_i = 1'b1;
      repeat (3) @(negedge clk);
      host_write(2'd2, 8'h5C);
      ss_i = 1'b0;
      repeat (2) @(negedge clk);
      slave_bits(8'h5C, 8'h27, 8, got);
      chk("R10 resync sent byte", int'(got), 8'h5C);
      host_read(2'd2, rd); chk("R10 resync received byte", int'(rd), 8'h27);

      // R10 select-enable off: always selected
      host_write(2'd1, 8'h00);
      ss_i = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 csen off always selected", int'(sdo_oe), 1);

      cmp_en = 0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule